// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block keeps a small table of 8-byte segment descriptors and screens every memory access against the one the access names. Software-side logic fills the table through a plain write port. Each access request names a table slot, a 32-bit offset, a kind (read, write or instruction fetch), a length of 1, 2, 4 or 8 bytes, and the requester's current privilege level (CPL). One cycle after the block accepts a request, it gives back either the linear address (segment base plus offset) or a fault with a reason code.

Requests and responses each use a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the response register is empty or is being drained in the same cycle, so a consumer that holds `rsp_ready` high can take one result per cycle. While `rsp_valid` is high and `rsp_ready` is low, the response stays fixed and no new request is taken.

A table write takes effect at the next edge. A request accepted on the same edge as a write to its own slot is checked against the old contents.

Top module: `seg_access_checker`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1 and every table slot holds all zeros, so any access to a nonzero slot faults with code 2 until that slot is written.
- R2: A slot written with `wr_en` holds the descriptor in this layout: limit[15:0] in bits 15:0, base[23:0] in bits 39:16, the access byte in bits 47:40 (bit 41 read/write enable, bit 42 conforming, bit 43 executable, bit 44 code/data type, bits 46:45 DPL, bit 47 present), limit[19:16] in bits 51:48, granularity in bit 55, and base[31:24] in bits 63:56.
- R3: An access to slot 0 always faults with code 1, whatever that slot holds.
- R4: An access through a descriptor with the present bit at 0 faults with code 2.
- R5: An access of N bytes at offset X faults with code 3 when X+N-1, computed without wrapping, exceeds the effective limit. With granularity 0 the effective limit is the 20-bit limit in bytes. With granularity 1 it is (limit << 12) | 0xFFF. `req_len` encodes N as 0→1, 1→2, 2→4 and 3→8.
- R6: For a data segment (executable 0), reads are allowed, writes are allowed only when the read/write bit is 1, and a fetch is a type fault (code 4). `req_kind` is encoded as 0 read, 1 write, 2 fetch. Kind 3 is always a type fault.
- R7: For a code segment (executable 1), writes are a type fault, reads are allowed only when the read/write bit is 1, and fetches are allowed. A descriptor with the code/data type bit at 0 is a type fault for every kind.
- R8: A read or a write faults with code 5 when CPL is numerically greater than DPL.
- R9: A fetch through conforming code faults with code 5 when CPL < DPL. A fetch through non-conforming code faults with code 5 when CPL ≠ DPL.
- R10: When several checks fail, the lowest nonzero code among null (1), not present (2), limit (3), type (4) and privilege (5) is reported.
- R11: An access with no fault returns code 0 and an address equal to base + offset modulo 2^32. A faulted response carries address 0.
- R12: The response appears in the cycle after acceptance and holds steady while `rsp_ready` is low. `req_ready` is low only while a response is pending and not being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 3 | Slot to write |
| wr_data | input | 64 | Descriptor contents |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_idx | input | 3 | Slot named by the request |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_len | input | 2 | Access length, log2 of bytes |
| req_cpl | input | 2 | Requester privilege level |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 3 | Fault code, 0 when allowed |
| rsp_addr | output | 32 | Linear address, 0 on fault |

## Verification
The hardest cases to reach are accesses whose last byte falls exactly on the effective limit, or one byte past it, under page granularity. They matter most when combined with a second failing check, because that is the only case where the priority order can be seen. Random offsets almost never land there. So the random generator draws most offsets from a small window below and above each descriptor's scaled limit, and directed cases stack limit, type and privilege failures together. Random back-pressure on `rsp_ready` exercises the hold behaviour on every transaction kind.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_NULL    = 3'd1,
    FLT_ABSENT  = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_TYPE    = 3'd4,
    FLT_PRIV    = 3'd5
  } fault_e;

  localparam int unsigned DESC_W  = 64;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned LIM_W   = 20;
  localparam int unsigned PAGE_SH = 12;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
    logic              present;
    logic [1:0]        dpl;
    logic              code_data;
    logic              exec;
    logic              conf_dir;
    logic              rw_en;
  } seg_desc_t;

  function automatic seg_desc_t unpack_desc(input logic [DESC_W-1:0] raw);
    seg_desc_t d;
    d.base      = {raw[63:56], raw[39:32], raw[31:16]};
    d.limit     = {raw[51:48], raw[15:0]};
    d.gran      = raw[55];
    d.present   = raw[47];
    d.dpl       = raw[46:45];
    d.code_data = raw[44];
    d.exec      = raw[43];
    d.conf_dir  = raw[42];
    d.rw_en     = raw[41];
    return d;
  endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import segchk_pkg::*;
#(
  parameter int unsigned NUM_DESC = 8,
  localparam int unsigned IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DESC_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output seg_desc_t         rd_desc
);

  logic [DESC_W-1:0] slot_q [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  logic [DESC_W-1:0] rd_raw;

  always_comb begin
    rd_raw = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (rd_idx == IDX_W'(i)) rd_raw = slot_q[i];
    end
  end

  assign rd_desc = unpack_desc(rd_raw);

endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
  import segchk_pkg::*;
#(
  parameter int unsigned OFF_W = ADDR_W,
  parameter int unsigned LEN_W = 2,
  localparam int unsigned EXT_W = OFF_W + 1
) (
  input  logic [LIM_W-1:0] limit,
  input  logic             gran,
  input  logic [OFF_W-1:0] offset,
  input  logic [LEN_W-1:0] len_log2,
  output logic             over
);

  logic [EXT_W-1:0] eff_lim;
  logic [EXT_W-1:0] last_byte;

  always_comb begin
    if (gran) eff_lim = EXT_W'({limit, {PAGE_SH{1'b1}}});
    else      eff_lim = EXT_W'(limit);
    last_byte = EXT_W'(offset) + (EXT_W'(1) << len_log2) - EXT_W'(1);
    over      = last_byte > eff_lim;
  end

endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import segchk_pkg::*;
(
  input  seg_desc_t  desc,
  input  acc_kind_e  kind,
  input  logic [1:0] cpl,
  output logic       type_bad,
  output logic       priv_bad
);

  logic code_bad;
  logic data_bad;

  always_comb begin
    code_bad = (kind == KIND_WRITE) || (kind == KIND_RSVD) ||
               ((kind == KIND_READ) && !desc.rw_en);
    data_bad = (kind == KIND_FETCH) || (kind == KIND_RSVD) ||
               ((kind == KIND_WRITE) && !desc.rw_en);
    type_bad = !desc.code_data || (desc.exec ? code_bad : data_bad);

    if (kind == KIND_FETCH) begin
      priv_bad = desc.conf_dir ? (cpl < desc.dpl) : (cpl != desc.dpl);
    end else begin
      priv_bad = cpl > desc.dpl;
    end
  end

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
  import segchk_pkg::*;
#(
  parameter int unsigned NUM_DESC = 8,
  parameter int unsigned LEN_W    = 2,
  localparam int unsigned IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DESC_W-1:0] wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [1:0]        req_kind,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_cpl,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_addr
);

  seg_desc_t desc;
  logic      lim_over;
  logic      type_bad;
  logic      priv_bad;
  acc_kind_e kind;
  fault_e    verdict;
  logic      accept;

  logic              rsp_valid_q;
  fault_e            rsp_fault_q;
  logic [ADDR_W-1:0] rsp_addr_q;

  assign kind = acc_kind_e'(req_kind);

  seg_desc_table #(.NUM_DESC(NUM_DESC)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (req_idx),
    .rd_desc (desc)
  );

  seg_limit_chk #(.OFF_W(ADDR_W), .LEN_W(LEN_W)) u_limit (
    .limit    (desc.limit),
    .gran     (desc.gran),
    .offset   (req_off),
    .len_log2 (req_len),
    .over     (lim_over)
  );

  seg_rights_chk u_rights (
    .desc     (desc),
    .kind     (kind),
    .cpl      (req_cpl),
    .type_bad (type_bad),
    .priv_bad (priv_bad)
  );

  // priority: the lowest code wins
  always_comb begin
    if (req_idx == '0)        verdict = FLT_NULL;
    else if (!desc.present)   verdict = FLT_ABSENT;
    else if (lim_over)        verdict = FLT_LIMIT;
    else if (type_bad)        verdict = FLT_TYPE;
    else if (priv_bad)        verdict = FLT_PRIV;
    else                      verdict = FLT_NONE;
  end

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= FLT_NONE;
      rsp_addr_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_fault_q <= verdict;
      rsp_addr_q  <= (verdict == FLT_NONE) ? (desc.base + req_off) : '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_addr  = rsp_addr_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_addr)); // R12

  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !req_valid |=> !rsp_valid); // R12

  AST_NULL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_idx == '0) |=> rsp_fault == FLT_NULL); // R3

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != FLT_NONE) |-> rsp_addr == '0); // R11

  AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= 3'd5); // R10

  AST_CODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && desc.code_data && desc.exec && (req_kind == 2'd1) |-> type_bad); // R7

  AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !desc.gran && (req_off > ADDR_W'(desc.limit)) |-> lim_over); // R5

endmodule

// File: tb/seg_access_checker_test.sv
`timescale 1ns/1ps
module seg_access_checker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_off = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_len = '0;
  logic [1:0]  req_cpl = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_addr;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] mirror [8];
  bit done = 0;

  always #10 clk = ~clk;

  seg_access_checker uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .req_off(req_off), .req_kind(req_kind), .req_len(req_len), .req_cpl(req_cpl),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_addr(rsp_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
      input bit g, input bit p, input logic [1:0] dpl, input bit s, input bit e,
      input bit dc, input bit rw);
    return {base[31:24], g, 1'b1, 1'b0, 1'b0, lim[19:16], p, dpl, s, e, dc, rw, 1'b0,
            base[23:0], lim[15:0]};
  endfunction

  // expected {fault, addr} from the requirements
  function automatic logic [34:0] model(input logic [2:0] idx, input logic [31:0] off,
      input logic [1:0] kind, input logic [1:0] len, input logic [1:0] cpl);
    logic [63:0] d = mirror[idx];
    logic [19:0] lim = {d[51:48], d[15:0]};
    logic [31:0] base = {d[63:56], d[39:16]};
    logic [32:0] eff = d[55] ? {1'b0, lim, 12'hFFF} : {13'd0, lim};
    logic [32:0] last = {1'b0, off} + (33'd1 << len) - 33'd1;
    bit s = d[44], e = d[43], c = d[42], rw = d[41];
    bit tbad, pbad;
    tbad = !s || kind == 2'd3 ||
           (e ? (kind == 2'd1 || (kind == 2'd0 && !rw))
              : (kind == 2'd2 || (kind == 2'd1 && !rw)));
    if (kind == 2'd2) pbad = c ? (cpl < d[46:45]) : (cpl != d[46:45]);
    else              pbad = cpl > d[46:45];
    if (idx == 0)          return {3'd1, 32'd0};
    else if (!d[47])       return {3'd2, 32'd0};
    else if (last > eff)   return {3'd3, 32'd0};
    else if (tbad)         return {3'd4, 32'd0};
    else if (pbad)         return {3'd5, 32'd0};
    return {3'd0, base + off};
  endfunction

  task automatic wr(input logic [2:0] idx, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    mirror[idx] = data;
  endtask

  task automatic access(input string tag, input logic [2:0] idx, input logic [31:0] off,
      input logic [1:0] kind, input logic [1:0] len, input logic [1:0] cpl, input bit hold);
    logic [34:0] exp = model(idx, off, kind, len, cpl);
    @(negedge clk);
    req_valid = 1'b1; req_idx = idx; req_off = off; req_kind = kind;
    req_len = len; req_cpl = cpl; rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R12 rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " fault"}, 64'(rsp_fault), 64'(exp[34:32]));
    check({tag, " addr"}, 64'(rsp_addr), 64'(exp[31:0]));
    if (hold) begin
      check({tag, " R12 ready low"}, 64'(req_ready), 64'd0);
      @(negedge clk);
      check({tag, " R12 held fault"}, 64'(rsp_fault), 64'(exp[34:32]));
      check({tag, " R12 held addr"}, 64'(rsp_addr), 64'(exp[31:0]));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (hold) check({tag, " R12 drained"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 req_ready after reset", 64'(req_ready), 64'd1);
    access("R1 empty slot", 3'd3, 32'd0, 2'd0, 2'd0, 2'd0, 1'b1);

    // R3: slot 0 faults even when filled
    wr(3'd0, mk(32'h1000, 20'hFFFFF, 1, 1, 2'd3, 1, 0, 0, 1));
    access("R3 null slot", 3'd0, 32'd4, 2'd0, 2'd0, 2'd0, 1'b0);

    // R2/R5 page granularity boundary
    wr(3'd1, mk(32'h1234_5678, 20'h00001, 1, 1, 2'd0, 1, 0, 0, 1));
    access("R5 gran last fit", 3'd1, 32'h1FFC, 2'd1, 2'd2, 2'd0, 1'b0);
    access("R5 gran one over", 3'd1, 32'h1FFD, 2'd1, 2'd2, 2'd0, 1'b0);
    access("R2 R11 base add", 3'd1, 32'h0010, 2'd0, 2'd0, 2'd0, 1'b0);

    // R5 byte granularity, 8-byte
    wr(3'd2, mk(32'h0000_8000, 20'h0000F, 0, 1, 2'd3, 1, 0, 0, 0));
    access("R5 byte fit", 3'd2, 32'h8, 2'd0, 2'd3, 2'd3, 1'b0);
    access("R5 byte over", 3'd2, 32'h9, 2'd0, 2'd3, 2'd3, 1'b0);
    access("R6 write read-only", 3'd2, 32'h0, 2'd1, 2'd0, 2'd3, 1'b0);
    access("R6 data fetch", 3'd2, 32'h0, 2'd2, 2'd0, 2'd3, 1'b0);
    access("R6 kind three", 3'd2, 32'h0, 2'd3, 2'd0, 2'd3, 1'b0);

    // R4 and R10 absent plus over limit
    wr(3'd4, mk(32'h0, 20'h0, 0, 0, 2'd0, 1, 0, 0, 1));
    access("R4 R10 absent beats limit", 3'd4, 32'hFF, 2'd0, 2'd0, 2'd0, 1'b0);

    // R7 R9 conforming and non-conforming code
    wr(3'd5, mk(32'h4000, 20'hFFF, 0, 1, 2'd1, 1, 1, 1, 0));
    wr(3'd6, mk(32'h6000, 20'hFFF, 0, 1, 2'd1, 1, 1, 0, 1));
    access("R9 conf fetch cpl3", 3'd5, 32'h10, 2'd2, 2'd2, 2'd3, 1'b0);
    access("R9 conf fetch cpl0", 3'd5, 32'h10, 2'd2, 2'd2, 2'd0, 1'b0);
    access("R7 exec-only read", 3'd5, 32'h10, 2'd0, 2'd0, 2'd1, 1'b0);
    access("R9 nonconf fetch cpl3", 3'd6, 32'h10, 2'd2, 2'd0, 2'd3, 1'b0);
    access("R9 nonconf fetch equal", 3'd6, 32'h10, 2'd2, 2'd0, 2'd1, 1'b0);
    access("R7 code write", 3'd6, 32'h10, 2'd1, 2'd0, 2'd1, 1'b0);
    access("R8 code read cpl3", 3'd6, 32'h10, 2'd0, 2'd0, 2'd3, 1'b0);
    access("R10 limit beats type", 3'd6, 32'hFFF, 2'd1, 2'd1, 2'd3, 1'b0);
    access("R10 type beats priv", 3'd5, 32'h0, 2'd1, 2'd0, 2'd3, 1'b0);

    // R7 system type, R8 data priv
    wr(3'd7, mk(32'h0, 20'hFFFFF, 1, 1, 2'd2, 0, 0, 0, 1));
    access("R7 system type", 3'd7, 32'h0, 2'd0, 2'd0, 2'd0, 1'b0);
    wr(3'd7, mk(32'hFFFF_F000, 20'hFFFFF, 1, 1, 2'd2, 1, 0, 0, 1));
    access("R8 data cpl3 dpl2", 3'd7, 32'h0, 2'd0, 2'd0, 2'd3, 1'b0);
    access("R11 address wrap", 3'd7, 32'h1000, 2'd1, 2'd0, 2'd2, 1'b0);
    access("R5 top offset 8B", 3'd7, 32'hFFFF_FFF8, 2'd0, 2'd3, 2'd0, 1'b0);
    access("R5 wrap past top", 3'd7, 32'hFFFF_FFFC, 2'd0, 2'd3, 2'd0, 1'b0);

    // R12 back-to-back: ready stays high while draining
    @(negedge clk);
    req_valid = 1'b1; req_idx = 3'd7; req_off = 32'h20; req_kind = 2'd0;
    req_len = 2'd0; req_cpl = 2'd0; rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 ready while draining", 64'(req_ready), 64'd1);
    req_off = 32'h40;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 second result addr", 64'(rsp_addr), 64'(32'hFFFF_F040));
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R12 idle after drain", 64'(rsp_valid), 64'd0);

    // constrained random
    for (int r = 0; r < 400; r++) begin
      if (r % 40 == 0) begin
        for (int k = 1; k < 8; k++) begin
          logic [19:0] lim = ($urandom % 4 == 0) ? 20'($urandom) : 20'($urandom % 64);
          wr(3'(k), mk($urandom, lim, ($urandom % 3 == 0), ($urandom % 8 != 0),
                       2'($urandom), ($urandom % 8 != 0), 1'($urandom),
                       1'($urandom), 1'($urandom)));
        end
      end
      begin
        logic [2:0]  idx = 3'($urandom);
        logic [63:0] d = mirror[idx];
        logic [31:0] eff = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'd0, d[51:48], d[15:0]};
        logic [31:0] off = ($urandom % 4 == 0) ? $urandom : eff - 32'd8 + 32'($urandom % 12);
        access("R5 R6 R7 R8 R9 R10 R11 random", idx, off, 2'($urandom % 3 + (($urandom % 20 == 0) ? 1 : 0)),
               2'($urandom), 2'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule